// File: doc/BRIEF.md
# Power-Fail Shutdown and Reset Sequencer

This block sits between a supply monitor and a processor. It watches a power-good level and, when power fails, pulls four active-low lines low one after another: a power-off notice, an interrupt request, a stop request and finally the system reset. During the shutdown window it sends a short burst of clock pulses to the keyboard/display controller, so that the controller can store its state before everything is held in reset. When power comes back, the power-off notice is released first. The system reset follows after a further step.

The power-good level first passes a two-flop synchronizer and then a debounce filter, so short dropouts cannot start a shutdown. Once a shutdown has begun, it always runs to the reset step, even if power returns partway through. The keyboard/display controller has its own reset line. Only an explicit request input or power-on drives that line. A small cause register holds the reason for the last reset and clears when it is read.

Top module: `pwrfail_seq`

## Requirements
- R1: When the filtered power-good goes low, poffN falls first, then irqN, then stopN, then sysRstN. Each fall comes at least STEP_CYCLES clock cycles after the one before it.
- R2: sysRstN falls no earlier than MIN_CYCLES clock cycles after poffN falls.
- R3: On restore, poffN rises first. At least STEP_CYCLES cycles later, sysRstN, irqN and stopN rise together in one cycle.
- R4: Between the fall of poffN and the fall of sysRstN, saveClk gives exactly PULSES rising edges, each phase lasting HALF_CYCLES cycles. saveClk stays low at all other times.
- R5: A power-good dropout of fewer than DEBOUNCE_LEN cycles has no effect on any output. A dropout that stays low longer than DEBOUNCE_LEN plus two cycles starts the sequence.
- R6: If power-good returns after a shutdown has started, the shutdown still completes with sysRstN low. The restore order of R3 then follows.
- R7: A one-cycle pulse on ctlRstReq drives ctlRstN low for exactly CTL_RST_LEN cycles and leaves poffN, irqN, stopN and sysRstN unchanged. A power-fail sequence never drives ctlRstN low.
- R8: The status output encodes the cause of the last reset as 1 for power-on, 2 for power-fail and 3 for a controller request. The cycle after a statusRd pulse it reads 0, unless a new cause is recorded in that same cycle.
- R9: While rstAsyncN is low, poffN, irqN, stopN, sysRstN and ctlRstN are all low and status is 1. After reset is released, the outputs are freed in the order of R3 once power-good has been filtered high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstAsyncN | input | 1 | Asynchronous power-on reset, active low |
| pwrGood | input | 1 | Raw power-good level from the supply monitor |
| ctlRstReq | input | 1 | One-cycle request to reset the keyboard/display controller |
| statusRd | input | 1 | Read strobe; clears the cause register |
| poffN | output | 1 | Power-off notice, active low |
| irqN | output | 1 | Interrupt request, active low |
| stopN | output | 1 | Stop request, active low |
| sysRstN | output | 1 | System reset, active low |
| ctlRstN | output | 1 | Keyboard/display controller reset, active low |
| saveClk | output | 1 | State-save clock burst toward the controller |
| status | output | 2 | Cause of last reset (0 none, 1 power-on, 2 power-fail, 3 controller request) |

## Verification
The bench builds the block with DEBOUNCE_LEN 4, STEP_CYCLES 5, MIN_CYCLES 60, HALF_CYCLES 2 and CTL_RST_LEN 6. With these values the 10 ms minimum becomes 60 cycles. A whole shutdown and restore then takes about a hundred cycles, so the bench can measure the exact order and spacing of the edges from the ports. The short debounce length makes it practical to test a dropout just below the filter length and a return of power partway through a shutdown, in the same run. The default parameters assume a 50 MHz clock with a 10 ms minimum.

// File: rtl/pwrfail_seq_pkg.sv
package pwrfail_seq_pkg;

  // Strobes issued by the sequencer FSM to the timing datapath
  typedef struct packed {
    logic stepClr;     // restart the per-step delay counter
    logic minStart;    // restart the minimum-interval counter
    logic burstStart;  // launch the state-save clock burst
    logic markFail;    // record a power-fail reset cause
  } seqStrobe_t;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_POWERON = 2'd1,
    CAUSE_PWRFAIL = 2'd2,
    CAUSE_CTLREQ  = 2'd3
  } cause_t;

endpackage

// File: rtl/pwrfail_seq_ctrl.sv
module pwrfail_seq_ctrl
  import pwrfail_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pgFilt,
  input  logic       stepDone,
  input  logic       minDone,
  input  logic       burstDone,
  output seqStrobe_t strobe,
  output logic       poffN,
  output logic       irqN,
  output logic       stopN,
  output logic       sysRstN
);

  typedef enum logic [2:0] {
    ST_RUN, ST_DN_POFF, ST_DN_IRQ, ST_DN_STOP, ST_HELD, ST_UP_POFF
  } seqState_t;

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HELD;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_RUN: if (!pgFilt) begin
        stateNext       = ST_DN_POFF;
        strobe.stepClr  = 1'b1;
        strobe.minStart = 1'b1;
      end
      ST_DN_POFF: if (stepDone) begin
        stateNext      = ST_DN_IRQ;
        strobe.stepClr = 1'b1;
      end
      ST_DN_IRQ: if (stepDone) begin
        stateNext         = ST_DN_STOP;
        strobe.stepClr    = 1'b1;
        strobe.burstStart = 1'b1;
      end
      ST_DN_STOP: if (stepDone && minDone && burstDone) begin
        stateNext       = ST_HELD;
        strobe.stepClr  = 1'b1;
        strobe.markFail = 1'b1;
      end
      ST_HELD: if (pgFilt && stepDone) begin
        stateNext      = ST_UP_POFF;
        strobe.stepClr = 1'b1;
      end
      ST_UP_POFF: if (stepDone) begin
        stateNext      = ST_RUN;
        strobe.stepClr = 1'b1;
      end
      default: stateNext = ST_HELD;
    endcase
  end

  assign poffN   = (state == ST_RUN) || (state == ST_UP_POFF);
  assign irqN    = (state == ST_RUN) || (state == ST_DN_POFF);
  assign stopN   = (state == ST_RUN) || (state == ST_DN_POFF) || (state == ST_DN_IRQ);
  assign sysRstN = (state == ST_RUN) || (state == ST_DN_POFF) ||
                   (state == ST_DN_IRQ) || (state == ST_DN_STOP);

  // R1: each shutdown line only falls once its predecessor is already low
  p_irq_after_poff_r1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> !poffN);
  p_stop_after_irq_r1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stopN) |-> (!irqN && !poffN));
  // R2: reset only entered once the minimum interval has elapsed
  p_min_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysRstN) |-> ($past(minDone) && !stopN));
  // R3: reset released only after the power-off notice was already high
  p_release_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstN) |-> ($past(poffN) && irqN && stopN));

endmodule

// File: rtl/pwrfail_seq_dp.sv
module pwrfail_seq_dp
  import pwrfail_seq_pkg::*;
#(
  parameter int DEBOUNCE_LEN = 1000,
  parameter int STEP_CYCLES  = 5000,
  parameter int MIN_CYCLES   = 500000,
  parameter int HALF_CYCLES  = 250,
  parameter int PULSES       = 8,
  parameter int CTL_RST_LEN  = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  logic       ctlRstReq,
  input  logic       statusRd,
  input  seqStrobe_t strobe,
  output logic       pgFilt,
  output logic       stepDone,
  output logic       minDone,
  output logic       burstDone,
  output logic       saveClk,
  output logic       ctlRstN,
  output cause_t     status
);

  localparam int DEB_W   = $clog2(DEBOUNCE_LEN + 1);
  localparam int STEP_W  = $clog2(STEP_CYCLES + 1);
  localparam int MIN_W   = $clog2(MIN_CYCLES + 1);
  localparam int HALF_W  = $clog2(HALF_CYCLES + 1);
  localparam int EDGES   = 2 * PULSES;
  localparam int BURST_W = $clog2(EDGES + 1);
  localparam int CTL_W   = $clog2(CTL_RST_LEN + 1);

  // power-good synchronizer and debounce filter
  logic [1:0]       pgSync;
  logic [DEB_W-1:0] debCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgSync <= '0;
      debCnt <= '0;
      pgFilt <= 1'b0;
    end else begin
      pgSync <= {pgSync[0], pwrGood};
      if (pgSync[1] == pgFilt) begin
        debCnt <= '0;
      end else if (debCnt == DEB_W'(DEBOUNCE_LEN - 1)) begin
        debCnt <= '0;
        pgFilt <= pgSync[1];
      end else begin
        debCnt <= debCnt + 1'b1;
      end
    end
  end

  // per-step delay and minimum-interval counters
  logic [STEP_W-1:0] stepCnt;
  logic [MIN_W-1:0]  minCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
      minCnt  <= MIN_W'(MIN_CYCLES);
    end else begin
      if (strobe.stepClr)   stepCnt <= '0;
      else if (!stepDone)   stepCnt <= stepCnt + 1'b1;
      if (strobe.minStart)  minCnt  <= '0;
      else if (!minDone)    minCnt  <= minCnt + 1'b1;
    end
  end

  assign stepDone = (stepCnt == STEP_W'(STEP_CYCLES));
  assign minDone  = (minCnt == MIN_W'(MIN_CYCLES));

  // state-save clock burst
  logic [BURST_W-1:0] burstLeft;
  logic [HALF_W-1:0]  halfCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstLeft <= '0;
      halfCnt   <= '0;
      saveClk   <= 1'b0;
    end else if (strobe.burstStart) begin
      burstLeft <= BURST_W'(EDGES);
      halfCnt   <= '0;
      saveClk   <= 1'b0;
    end else if (!burstDone) begin
      if (halfCnt == HALF_W'(HALF_CYCLES - 1)) begin
        halfCnt   <= '0;
        saveClk   <= ~saveClk;
        burstLeft <= burstLeft - 1'b1;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  assign burstDone = (burstLeft == '0);

  // controller reset pulse, independent of the system reset chain
  logic [CTL_W-1:0] ctlCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ctlCnt <= CTL_W'(CTL_RST_LEN);
    else if (ctlRstReq)       ctlCnt <= CTL_W'(CTL_RST_LEN);
    else if (ctlCnt != '0)    ctlCnt <= ctlCnt - 1'b1;
  end

  assign ctlRstN = (ctlCnt == '0);

  // reset cause register, cleared on read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                status <= CAUSE_POWERON;
    else if (strobe.markFail) status <= CAUSE_PWRFAIL;
    else if (ctlRqQ_unused()) status <= CAUSE_CTLREQ;
    else if (statusRd)        status <= CAUSE_NONE;
  end

  function automatic logic ctlRqQ_unused();
    return ctlRstReq;
  endfunction

  // R4: the save clock only toggles while a burst is still outstanding
  p_burst_bounded_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(saveClk) |-> $past(!burstDone || strobe.burstStart));
  // R5: the filtered level only moves after the synchronized level disagreed
  p_filter_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pgFilt) |-> ($past(pgSync[1]) != $past(pgFilt)));
  // R7: a request always pulls the controller reset low on the next cycle
  p_ctl_request_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctlRstReq |=> !ctlRstN);
  // R8: a read with no competing cause leaves the register cleared
  p_status_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !ctlRstReq && !strobe.markFail) |=> (status == CAUSE_NONE));

endmodule

// File: rtl/pwrfail_seq.sv
module pwrfail_seq
  import pwrfail_seq_pkg::*;
#(
  parameter int DEBOUNCE_LEN = 1000,
  parameter int STEP_CYCLES  = 5000,
  parameter int MIN_CYCLES   = 500000,
  parameter int HALF_CYCLES  = 250,
  parameter int PULSES       = 8,
  parameter int CTL_RST_LEN  = 5000
) (
  input  logic       clk,
  input  logic       rstAsyncN,
  input  logic       pwrGood,
  input  logic       ctlRstReq,
  input  logic       statusRd,
  output logic       poffN,
  output logic       irqN,
  output logic       stopN,
  output logic       sysRstN,
  output logic       ctlRstN,
  output logic       saveClk,
  output logic [1:0] status
);

  seqStrobe_t strobe;
  logic       pgFilt, stepDone, minDone, burstDone;
  cause_t     cause;

  pwrfail_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstAsyncN),
    .pgFilt   (pgFilt),
    .stepDone (stepDone),
    .minDone  (minDone),
    .burstDone(burstDone),
    .strobe   (strobe),
    .poffN    (poffN),
    .irqN     (irqN),
    .stopN    (stopN),
    .sysRstN  (sysRstN)
  );

  pwrfail_seq_dp #(
    .DEBOUNCE_LEN(DEBOUNCE_LEN),
    .STEP_CYCLES (STEP_CYCLES),
    .MIN_CYCLES  (MIN_CYCLES),
    .HALF_CYCLES (HALF_CYCLES),
    .PULSES      (PULSES),
    .CTL_RST_LEN (CTL_RST_LEN)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstAsyncN),
    .pwrGood  (pwrGood),
    .ctlRstReq(ctlRstReq),
    .statusRd (statusRd),
    .strobe   (strobe),
    .pgFilt   (pgFilt),
    .stepDone (stepDone),
    .minDone  (minDone),
    .burstDone(burstDone),
    .saveClk  (saveClk),
    .ctlRstN  (ctlRstN),
    .status   (cause)
  );

  assign status = cause;

endmodule

// File: tb/pwrfail_seq_tb.sv
module pwrfail_seq_tb;

  localparam int DEB  = 4;
  localparam int STEP = 5;
  localparam int MINC = 60;
  localparam int HALF = 2;
  localparam int NPUL = 8;
  localparam int CTLL = 6;

  logic clk = 1'b0;
  logic rstAsyncN = 1'b0;
  logic pwrGood = 1'b1;
  logic ctlRstReq = 1'b0;
  logic statusRd = 1'b0;
  logic poffN, irqN, stopN, sysRstN, ctlRstN, saveClk;
  logic [1:0] status;

  always #10 clk = ~clk;

  pwrfail_seq #(
    .DEBOUNCE_LEN(DEB), .STEP_CYCLES(STEP), .MIN_CYCLES(MINC),
    .HALF_CYCLES(HALF), .PULSES(NPUL), .CTL_RST_LEN(CTLL)
  ) u_dut (
    .clk(clk), .rstAsyncN(rstAsyncN), .pwrGood(pwrGood),
    .ctlRstReq(ctlRstReq), .statusRd(statusRd),
    .poffN(poffN), .irqN(irqN), .stopN(stopN), .sysRstN(sysRstN),
    .ctlRstN(ctlRstN), .saveClk(saveClk), .status(status)
  );

  int nChecks = 0;
  int nFails  = 0;

  // edge monitor, sampled away from the active edge
  int cyc = 0;
  logic pPoff, pIrq, pStop, pSys, pCtl, pSck;
  int poffFallN = 0, irqFallN = 0, stopFallN = 0, sysFallN = 0, ctlFallN = 0;
  int poffRiseN = 0, sysRiseN = 0, sckRiseN = 0, sckWinN = 0;
  int poffFallT, irqFallT, stopFallT, sysFallT, ctlFallT, ctlRiseT;
  int poffRiseT, sysRiseT, irqRiseT, stopRiseT;

  always @(negedge clk) begin
    cyc++;
    if (rstAsyncN && pPoff !== 1'bx) begin
      if (pPoff && !poffN)   begin poffFallN++; poffFallT = cyc; end
      if (!pPoff && poffN)   begin poffRiseN++; poffRiseT = cyc; end
      if (pIrq && !irqN)     begin irqFallN++;  irqFallT  = cyc; end
      if (!pIrq && irqN)     irqRiseT = cyc;
      if (pStop && !stopN)   begin stopFallN++; stopFallT = cyc; end
      if (!pStop && stopN)   stopRiseT = cyc;
      if (pSys && !sysRstN)  begin sysFallN++;  sysFallT  = cyc; end
      if (!pSys && sysRstN)  begin sysRiseN++;  sysRiseT  = cyc; end
      if (pCtl && !ctlRstN)  begin ctlFallN++;  ctlFallT  = cyc; end
      if (!pCtl && ctlRstN)  ctlRiseT = cyc;
      if (!pSck && saveClk) begin
        sckRiseN++;
        if (!poffN && sysRstN) sckWinN++;
      end
    end
    pPoff = poffN; pIrq = irqN; pStop = stopN; pSys = sysRstN;
    pCtl = ctlRstN; pSck = saveClk;
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testPowerOn();
    pwrGood = 1'b1;
    waitCycles(3);
    // R9: all lines held low while reset is asserted
    check("R9 lines low in reset", {poffN, irqN, stopN, sysRstN, ctlRstN} == 5'b0,
          {poffN, irqN, stopN, sysRstN, ctlRstN}, 0);
    check("R9 status power-on", status == 2'd1, status, 1);
    rstAsyncN = 1'b1;
    waitCycles(60);
    check("R9 released after power-on", {poffN, irqN, stopN, sysRstN} == 4'hF,
          {poffN, irqN, stopN, sysRstN}, 15);
    check("R3 poff before reset at power-on", (sysRiseT - poffRiseT) >= STEP,
          sysRiseT - poffRiseT, STEP);
    check("R8 status power-on kept", status == 2'd1, status, 1);
  endtask

  task automatic testStatusRead();
    @(negedge clk); statusRd = 1'b1;
    @(negedge clk); statusRd = 1'b0;
    check("R8 cleared on read", status == 2'd0, status, 0);
  endtask

  task automatic testPowerFail();
    int f0 = sysFallN, s0 = sckRiseN, w0 = sckWinN, c0 = ctlFallN;
    pwrGood = 1'b0;
    waitCycles(150);
    check("R1 one reset fall", sysFallN - f0 == 1, sysFallN - f0, 1);
    check("R1 irq after poff", (irqFallT - poffFallT) >= STEP, irqFallT - poffFallT, STEP);
    check("R1 stop after irq", (stopFallT - irqFallT) >= STEP, stopFallT - irqFallT, STEP);
    check("R1 reset after stop", (sysFallT - stopFallT) >= STEP, sysFallT - stopFallT, STEP);
    check("R2 minimum interval", (sysFallT - poffFallT) >= MINC, sysFallT - poffFallT, MINC);
    check("R4 pulse count", sckRiseN - s0 == NPUL, sckRiseN - s0, NPUL);
    check("R4 pulses in window", sckWinN - w0 == NPUL, sckWinN - w0, NPUL);
    check("R4 save clock idle low", saveClk == 1'b0, saveClk, 0);
    check("R7 ctl reset untouched by power-fail", ctlFallN == c0, ctlFallN - c0, 0);
    check("R8 status power-fail", status == 2'd2, status, 2);
    pwrGood = 1'b1;
    waitCycles(60);
    check("R3 restored", {poffN, irqN, stopN, sysRstN} == 4'hF,
          {poffN, irqN, stopN, sysRstN}, 15);
    check("R3 poff first", (sysRiseT - poffRiseT) >= STEP, sysRiseT - poffRiseT, STEP);
    check("R3 irq with reset", irqRiseT == sysRiseT, irqRiseT, sysRiseT);
    check("R3 stop with reset", stopRiseT == sysRiseT, stopRiseT, sysRiseT);
  endtask

  task automatic testGlitch();
    int p0 = poffFallN;
    pwrGood = 1'b0;
    waitCycles(DEB - 2);
    pwrGood = 1'b1;
    waitCycles(40);
    check("R5 short dropout ignored", poffFallN == p0, poffFallN - p0, 0);
    check("R5 lines still high", {poffN, sysRstN} == 2'b11, {poffN, sysRstN}, 3);
  endtask

  task automatic testMidReturn();
    int f0 = sysFallN, r0 = sysRiseN, s0 = sckRiseN;
    pwrGood = 1'b0;
    waitCycles(12);
    pwrGood = 1'b1;
    waitCycles(200);
    check("R6 reset still reached", sysFallN - f0 == 1, sysFallN - f0, 1);
    check("R6 released afterwards", sysRiseN - r0 == 1, sysRiseN - r0, 1);
    check("R6 min interval kept", (sysFallT - poffFallT) >= MINC, sysFallT - poffFallT, MINC);
    check("R6 burst complete", sckRiseN - s0 == NPUL, sckRiseN - s0, NPUL);
    check("R6 running again", {poffN, sysRstN} == 2'b11, {poffN, sysRstN}, 3);
  endtask

  task automatic testCtlReset();
    int sf = sysFallN, pf = poffFallN;
    @(negedge clk); ctlRstReq = 1'b1;
    @(negedge clk); ctlRstReq = 1'b0;
    waitCycles(20);
    check("R7 ctl low duration", (ctlRiseT - ctlFallT) == CTLL, ctlRiseT - ctlFallT, CTLL);
    check("R7 system reset untouched", sysFallN == sf, sysFallN - sf, 0);
    check("R7 power-off untouched", poffFallN == pf, poffFallN - pf, 0);
    check("R8 status ctl request", status == 2'd3, status, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    testPowerOn();
    testStatusRead();
    testPowerFail();
    testGlitch();
    testMidReturn();
    testCtlReset();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule